// File: doc/BRIEF.md
# Presence-Detect Serial Identification Store

This block is a two-wire serial slave that holds a 256-byte identification image. A fast system clock samples the open-drain SCL and SDA lines. The block never drives SDA high. It only pulls the line low through an output-enable, and a pad outside the block turns that enable into an open-drain driver. Both inputs pass through a synchronizer and a persistence filter, so the slave does not see short pulses on either line.

A master starts a transaction with a start condition and then sends a device address. That address is a fixed 1010 prefix followed by three strap pins. In a write, the first byte after the address loads the internal word pointer, and each later byte is stored at the pointer. In a read, bytes are returned from the pointer for as long as the master keeps acknowledging. The pointer advances after every byte in either direction.

The lower half of the store holds factory data and cannot be written. The upper half is free for system use. The whole image comes from a parameter at reset. A stop condition is the only way into standby. After the master refuses a read byte, the slave goes silent and stays silent until the next stop or start.

Top module: `idstore_i2c_slave`

## Requirements
- R1: After reset, and in standby, the slave leaves SDA released. Bytes clocked on the bus without a preceding start condition are never acknowledged.
- R2: A start is SDA falling while SCL is high, and it arms address reception from any state. A stop is SDA rising while SCL is high, and it returns the slave to standby. A transaction cut short by a stop leaves the pointer it has already set.
- R3: The slave acknowledges an address byte only when its upper seven bits equal binary 1010 followed by strap_i[2:0]. Bit 0 of that byte is the direction: 0 means write, 1 means read. On a mismatch the slave sends no acknowledge and leaves SDA alone until the next start or stop.
- R4: In a write, the slave acknowledges every byte after the address. The first of those bytes becomes the word pointer.
- R5: A data byte written to a location whose pointer bit 7 is set (128 to 255) is stored. A data byte written to a location 0 to 127 is acknowledged but not stored.
- R6: In a read, the slave sends the byte at the pointer, most significant bit first. It changes SDA only while SCL is low. It sends the next byte each time the master acknowledges.
- R7: After the master does not acknowledge a read byte, the slave releases SDA. It then drives nothing through any further clock pulses until a stop or a start.
- R8: The pointer increments by one after every byte read or written, and it wraps from 255 to 0.
- R9: The slave ignores a pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks. With the default of 10 clocks at 100 MHz, that is a pulse shorter than 100 ns.
- R10: After reset, location i holds byte i of the INIT_IMAGE parameter. By default that byte is (7*i + 3) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Board straps, the low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Most internal faults in this slave show up on SDA within one bit time, which is four SCL quarter periods. A phase register that takes the wrong branch shows up as a missing or extra acknowledge on the ninth clock of that byte. A wrong pointer or a broken write gate is not visible during the write itself. It shows up only in a later read, as a wrong data byte, and the random write-then-read sweeps are there to catch it. A filter that is too weak, or a standby state that gets entered too early, shows up as an acknowledge where the bench expects the line to stay high.

// File: rtl/idstore_pkg.sv
package idstore_pkg;
  localparam int unsigned AW    = 8;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned IMG_W = DEPTH * 8;
  localparam logic [3:0]  DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_WPTR, PH_WDATA, PH_ACK, PH_RDATA, PH_RACK, PH_MUTE
  } phase_t;

  function automatic logic addr_hit(input logic [6:0] dev, input logic [2:0] strap);
    return dev == {DEV_PREFIX, strap};
  endfunction

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic user_half(input logic [AW-1:0] p);
    return p[AW-1];
  endfunction

  function automatic logic [IMG_W-1:0] default_image();
    logic [IMG_W-1:0] img;
    img = '0;
    for (int i = 0; i < int'(DEPTH); i++) img[i*8 +: 8] = 8'((i * 7 + 3) % 256);
    return img;
  endfunction
endpackage

// File: rtl/idstore_filter.sv
module idstore_filter #(
  parameter int unsigned HOLD    = 10,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          seen;

  assign seen = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {2{IDLE_LV}};
      clean_o <= IDLE_LV;
      run_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (seen != clean_o) begin
        if (run_q == CW'(HOLD - 1)) begin
          clean_o <= seen;
          run_q   <= '0;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  // R9: a new level is only taken after it has persisted at the synchronizer
  assert_filter_persist_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean_o) |-> ($past(seen, 1) == clean_o) && ($past(seen, 2) == clean_o));
endmodule

// File: rtl/idstore_array.sv
module idstore_array
  import idstore_pkg::*;
#(
  parameter logic [IMG_W-1:0] INIT = default_image()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= INIT[i*8 +: 8];
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  // R5: the factory half never sees a write strobe
  assert_factory_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> user_half(waddr_i));
endmodule

// File: rtl/idstore_ctrl.sv
module idstore_ctrl
  import idstore_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_c,
  input  logic          sda_c,
  input  logic [2:0]    strap_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [AW-1:0] ptr_o,
  output logic [7:0]    wdata_o
);
  phase_t       state, after;
  logic [3:0]   bits;
  logic [7:0]   shreg;
  logic [AW-1:0] ptr;
  logic         mack, scl_q, sda_q;
  logic         scl_rise, scl_fall, bus_start, bus_stop, byte_full;

  assign scl_rise  = scl_c & ~scl_q;
  assign scl_fall  = ~scl_c & scl_q;
  assign bus_start = scl_c & scl_q & sda_q & ~sda_c;
  assign bus_stop  = scl_c & scl_q & ~sda_q & sda_c;
  assign byte_full = (bits == 4'd8);

  assign we_o     = (state == PH_WDATA) & scl_fall & byte_full & user_half(ptr);
  assign wdata_o  = shreg;
  assign ptr_o    = ptr;
  assign sda_oe_o = (state == PH_ACK) | ((state == PH_RDATA) & ~shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      after <= PH_IDLE;
      bits  <= '0;
      shreg <= '0;
      ptr   <= '0;
      mack  <= 1'b1;
    end else if (bus_stop) begin
      state <= PH_IDLE;
    end else if (bus_start) begin
      state <= PH_ADDR;
      bits  <= '0;
    end else begin
      unique case (state)
        PH_ADDR, PH_WPTR, PH_WDATA: begin
          if (scl_rise && !byte_full) begin
            shreg <= {shreg[6:0], sda_c};
            bits  <= bits + 4'd1;
          end else if (scl_fall && byte_full) begin
            bits <= '0;
            if (state == PH_ADDR) begin
              if (addr_hit(shreg[7:1], strap_i)) begin
                state <= PH_ACK;
                after <= shreg[0] ? PH_RDATA : PH_WPTR;
              end else begin
                state <= PH_MUTE;
              end
            end else if (state == PH_WPTR) begin
              ptr   <= shreg;
              state <= PH_ACK;
              after <= PH_WDATA;
            end else begin
              ptr   <= ptr_next(ptr);
              state <= PH_ACK;
              after <= PH_WDATA;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            state <= after;
            bits  <= '0;
            if (after == PH_RDATA) begin
              shreg <= rdata_i;
              ptr   <= ptr_next(ptr);
            end
          end
        end
        PH_RDATA: begin
          if (scl_rise) begin
            bits <= bits + 4'd1;
          end else if (scl_fall) begin
            if (byte_full) begin
              state <= PH_RACK;
              bits  <= '0;
            end else begin
              shreg <= {shreg[6:0], 1'b1};
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) begin
            mack <= sda_c;
          end else if (scl_fall) begin
            if (!mack) begin
              shreg <= rdata_i;
              ptr   <= ptr_next(ptr);
              state <= PH_RDATA;
              bits  <= '0;
            end else begin
              state <= PH_MUTE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: stop leads to standby, start arms address reception
  assert_stop_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> state == PH_IDLE);
  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !bus_stop) |=> state == PH_ADDR);
  // R1 / R7: silent while in standby or after a refused byte
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE) |-> !sda_oe_o);
  assert_quiet_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_MUTE) |-> !sda_oe_o);
  // R6: SDA drive moves only while SCL is low (or right after a bus condition)
  assert_sda_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> (!scl_c || $past(bus_start || bus_stop)));
  // R8: the pointer steps by one with wrap, except when loaded from the bus
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && $past(state) != PH_WPTR) |-> ptr == $past(ptr) + AW'(1));
endmodule

// File: rtl/idstore_i2c_slave.sv
module idstore_i2c_slave
  import idstore_pkg::*;
#(
  parameter int unsigned      FILT_CYCLES = 10,
  parameter logic [IMG_W-1:0] INIT_IMAGE  = default_image()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  logic          scl_c, sda_c, we;
  logic [AW-1:0] ptr;
  logic [7:0]    wdata, rdata;

  idstore_filter #(.HOLD(FILT_CYCLES), .IDLE_LV(1'b1)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_c));
  idstore_filter #(.HOLD(FILT_CYCLES), .IDLE_LV(1'b1)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_c));

  idstore_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .sda_c(sda_c), .strap_i(strap_i),
    .rdata_i(rdata), .sda_oe_o(sda_oe_o), .we_o(we), .ptr_o(ptr), .wdata_o(wdata));

  idstore_array #(.INIT(INIT_IMAGE)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata));
endmodule

// File: tb/idstore_i2c_slave_test.sv
module idstore_i2c_slave_test;
  localparam int Q = 25;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       oe;
  wire        sda_line = m_sda & ~oe;

  idstore_i2c_slave uut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                         .strap_i(strap), .sda_oe_o(oe));

  int checks = 0, fails = 0;
  logic [7:0] model [256];
  logic [7:0] mptr = 8'd0;
  localparam logic [7:0] WADDR = 8'hAA, RADDR = 8'hAB;

  function automatic logic [7:0] img(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic m_start();
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, input int glitch_at, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wq(); m_sda = b[i];
      if (glitch_at == i) begin
        repeat (3) @(negedge clk); m_scl = 1'b1;
        repeat (4) @(negedge clk); m_scl = 1'b0;
      end
      wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
    end
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = sda_line; wq(); m_scl = 1'b0;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); m_scl = 1'b0;
    end
    wq(); m_sda = give_ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
  endtask

  task automatic write_seq(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] d;
    m_start();
    put_byte(WADDR, -1, a); check(a == 1'b0, "R3 addr ack", a, 0);
    put_byte(p, -1, a);     check(a == 1'b0, "R4 pointer ack", a, 0);
    mptr = p;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      put_byte(d, -1, a);
      check(a == 1'b0, mptr[7] ? "R4 data ack" : "R5 protected ack", a, 0);
      if (mptr[7]) model[mptr] = d;
      mptr = mptr + 8'd1;
    end
    m_stop();
  endtask

  task automatic read_cur(input int n, input string req);
    logic a;
    logic [7:0] d;
    m_start();
    put_byte(RADDR, -1, a); check(a == 1'b0, "R3 read addr ack", a, 0);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, d);
      check(d == model[mptr], req, d, model[mptr]);
      mptr = mptr + 8'd1;
    end
    m_stop();
  endtask

  task automatic read_at(input logic [7:0] p, input int n, input string req);
    logic a;
    m_start();
    put_byte(WADDR, -1, a); check(a == 1'b0, "R3 addr ack", a, 0);
    put_byte(p, -1, a);     check(a == 1'b0, "R4 pointer ack", a, 0);
    mptr = p;
    read_cur(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) model[i] = img(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1: reset state and no response without a start
    check(oe == 1'b0, "R1 reset release", oe, 0);
    put_byte(WADDR, -1, a); check(a == 1'b1, "R1 no start no ack", a, 1);
    m_stop();

    // R9: SDA glitch while SCL high must not count as a start
    repeat (5) @(negedge clk); m_sda = 1'b0; repeat (4) @(negedge clk); m_sda = 1'b1;
    put_byte(WADDR, -1, a); check(a == 1'b1, "R9 sda glitch ignored", a, 1);
    m_stop();

    // R3: wrong addresses get no ack and the slave stays off the line
    m_start();
    put_byte(8'hA0, -1, a); check(a == 1'b1, "R3 wrong strap nack", a, 1);
    put_byte(8'h00, -1, a); check(a == 1'b1, "R3 silent after mismatch", a, 1);
    m_stop();
    m_start();
    put_byte(8'h2A, -1, a); check(a == 1'b1, "R3 wrong prefix nack", a, 1);
    m_stop();

    // R10 / R6: initial image readout, then R7 silence after nack
    read_at(8'h00, 4, "R10 initial image");
    m_start();
    put_byte(RADDR, -1, a);
    get_byte(1'b0, d); check(d == model[mptr], "R6 single read", d, model[mptr]);
    mptr = mptr + 8'd1;
    get_byte(1'b0, d); check(d == 8'hFF, "R7 silent after nack", d, 8'hFF);
    m_stop();
    read_at(8'hC0, 2, "R10 upper image");

    // R5: factory half is write protected
    write_seq(8'h10, 2);
    read_at(8'h10, 2, "R5 factory unchanged");

    // R4 / R5 / R8: random writes, one wrapping into the protected half
    for (int t = 0; t < 3; t++) write_seq(8'($urandom_range(128, 250)), 3);
    write_seq(8'hFE, 4);
    check(mptr == 8'h02, "R8 pointer wrap on write", mptr, 2);

    // R6: random reads of the upper half, then a current-address read
    for (int t = 0; t < 3; t++) read_at(8'($urandom_range(128, 250)), 4, "R6 random read");
    read_cur(2, "R6 current address read");

    // R8: read across 255 -> 0
    read_at(8'hFE, 4, "R8 read wrap");

    // R9: SCL glitch inside a data bit does not add a bit
    m_start();
    put_byte(WADDR, -1, a);
    put_byte(8'h90, -1, a);
    put_byte(8'h3C, 3, a); check(a == 1'b0, "R9 glitch byte ack", a, 0);
    m_stop();
    model[8'h90] = 8'h3C;
    read_at(8'h90, 1, "R9 scl glitch ignored");

    // R2: stop mid-transaction; bytes without start ignored; pointer kept
    m_start();
    put_byte(WADDR, -1, a);
    put_byte(8'hA0, -1, a);
    m_stop();
    mptr = 8'hA0;
    put_byte(WADDR, -1, a); check(a == 1'b1, "R2 ignored after stop", a, 1);
    put_byte(8'h33, -1, a); check(a == 1'b1, "R2 still ignored", a, 1);
    m_stop();
    read_cur(1, "R2 pointer kept after stop");

    summary();
    $finish;
  end
endmodule